// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single 16-bit timer channel that advances on a timer clock enable. Each channel takes a starting count and an operating mode through a load strobe. A gate input may hold the count or restart it. From those it produces an output waveform and a readable count. Six waveform modes are built in. Two are one-shots that hold their level after the count runs out. One gives a single-tick pulse at a fixed rate and one gives a square wave. The last two each give a single strobe pulse, one started by the load and one restarted by the gate.

Host-bus decoding, control-word parsing and count latching live in a separate block. That block drives `load`, `load_val` and `mode`, and samples `count` whenever software asks for a readback. The mode is captured with the load strobe. All waveforms are described in terms of counted ticks since the last load or restart. A counted tick is a cycle with `tick` high that the gate does not suspend.

Top module: `pic_channel`

## Requirements
- R1: A loaded value of 0 stands for 65536. Right after such a load `count` reads 0x0000, and after one counted tick in mode 0 it reads 0xFFFF.
- R2: Mode 0: `out` is low from the load until the counted ticks reach the count, then goes high and stays high.
- R3: Mode 1: `out` is high while the counted ticks are below the count and low from then on.
- R4: Mode 2: `out` is high exactly while the counted ticks d are nonzero and d mod N is 0, where N is the count.
- R5: Mode 3: `out` is high when (d mod N) < (N+1)/2 and low otherwise, repeating without end.
- R6: Modes 4 and 5: `out` is high only while d equals N, which is one tick long, and low at all other times.
- R7: In modes 1, 2, 3 and 5, a rising edge on `gate` sets d back to 0 without changing N.
- R8: In modes 0 and 4, ticks are not counted while `gate` is low, and `count` holds its value.
- R9: `count` reads (N - d) mod 65536 in modes 0, 1, 4 and 5. It reads N - (d mod N) in mode 2 and N - ((2d) mod N) in mode 3, both taken mod 65536.
- R10: A load sets d to 0 with the new N, and the next cycle reads `count` equal to `load_val`. A load takes priority over a tick or a gate edge in the same cycle.
- R11: Mode codes 6 and 7 behave exactly as modes 2 and 3.
- R12: After reset and until the first load, `out` is low and `count` reads 0.
- R13: `mode` is sampled only on a load cycle. Changing it at other times has no effect on `out` or `count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timer clock enable, one counting step per high cycle |
| load | input | 1 | Load strobe: capture `load_val` and `mode`, restart counting |
| load_val | input | 16 | Initial count, 0 meaning 65536 |
| mode | input | 3 | Operating mode code, sampled with `load` |
| gate | input | 1 | Gate level: suspends modes 0/4, rising edge restarts modes 1/2/3/5 |
| out | output | 1 | Mode-dependent output waveform |
| count | output | 16 | Current readable count |

## Verification
Several rules are checked on every cycle by the assertions:
- the readback equals the loaded value one cycle after a load;
- the mode 0 output stays high once it has risen;
- the strobe and rate pulses drop after one counted tick;
- the count is frozen while the gate suspends modes 0 and 4;
- the output is quiet before the first load.

The exact waveform shapes need the bench's elapsed-tick model, sampled on every cycle over random loads, gates and ticks. These are the odd-count square wave, the readback arithmetic in each mode, gate restarts, the 65536 wrap and the mode 6/7 aliases.

// File: rtl/pic_pkg.sv
// Package: shared mode type and mode classification helpers for the
// interval counter channel. Assumes 3-bit mode codes; 6 and 7 alias 2 and 3.
package pic_pkg;

    typedef enum logic [2:0] {
        PM_TERM    = 3'd0,
        PM_ONESHOT = 3'd1,
        PM_RATE    = 3'd2,
        PM_SQUARE  = 3'd3,
        PM_SW_STB  = 3'd4,
        PM_HW_STB  = 3'd5
    } pic_mode_e;

    // Fold the aliased codes onto their base modes.
    function automatic pic_mode_e pic_norm_mode(input logic [2:0] code);
        case (code)
            3'd6:    return PM_RATE;
            3'd7:    return PM_SQUARE;
            default: return pic_mode_e'(code);
        endcase
    endfunction

    // Modes whose waveform repeats with period N.
    function automatic logic pic_is_periodic(input pic_mode_e m);
        return (m == PM_RATE) || (m == PM_SQUARE);
    endfunction

    // Modes restarted by a gate rising edge.
    function automatic logic pic_gate_restarts(input pic_mode_e m);
        return (m == PM_ONESHOT) || (m == PM_RATE) ||
               (m == PM_SQUARE) || (m == PM_HW_STB);
    endfunction

    // Modes whose counting is held while gate is low.
    function automatic logic pic_gate_holds(input pic_mode_e m);
        return (m == PM_TERM) || (m == PM_SW_STB);
    endfunction

endpackage

// File: rtl/pic_gate_edge.sv
// Module: registers the gate level and flags its rising edge.
// Assumes gate is already synchronous to clk.
module pic_gate_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    output logic gate_rise
);
    logic gate_q;

    // Hold the previous gate level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate;
    end

    assign gate_rise = gate & ~gate_q;

    // A rising edge cannot be reported two cycles running (R7 edge detect).
    assert_rise_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        gate_rise |=> !gate_rise);

endmodule

// File: rtl/pic_tick_counter.sv
// Module: channel state. Holds the captured mode and count N, a phase
// counter and a free-running low elapsed count. In periodic modes the phase
// wraps at N. In one-shot modes it saturates at N+1. Assumes load has
// priority over restart, and restart has priority over a tick.
module pic_tick_counter #(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 load,
    input  logic [CNT_W-1:0]     load_val,
    input  logic [2:0]           mode_in,
    input  logic                 gate,
    input  logic                 gate_rise,
    output logic                 armed,
    output pic_pkg::pic_mode_e   mode_q,
    output logic [CNT_W:0]       init_cnt,
    output logic [CNT_W:0]       phase,
    output logic                 started,
    output logic [CNT_W-1:0]     elapsed,
    output logic                 count_en,
    output logic                 restart
);
    import pic_pkg::*;

    localparam int EXT_W = CNT_W + 1;

    logic [EXT_W-1:0] phase_inc;
    logic [EXT_W-1:0] phase_nxt;

    assign restart  = armed && gate_rise && pic_gate_restarts(mode_q);
    assign count_en = armed && tick && !(pic_gate_holds(mode_q) && !gate);
    assign phase_inc = phase + EXT_W'(1);

    // Next phase: wrap at N in periodic modes, stop past N otherwise.
    always_comb begin
        if (pic_is_periodic(mode_q))
            phase_nxt = (phase_inc == init_cnt) ? '0 : phase_inc;
        else
            phase_nxt = (phase > init_cnt) ? phase : phase_inc;
    end

    // Channel state update: load, then restart, then counted tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed    <= 1'b0;
            mode_q   <= PM_TERM;
            init_cnt <= '0;
            phase    <= '0;
            started  <= 1'b0;
            elapsed  <= '0;
        end else if (load) begin
            armed    <= 1'b1;
            mode_q   <= pic_norm_mode(mode_in);
            init_cnt <= (load_val == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, load_val};
            phase    <= '0;
            started  <= 1'b0;
            elapsed  <= '0;
        end else if (restart) begin
            phase    <= '0;
            started  <= 1'b0;
            elapsed  <= '0;
        end else if (count_en) begin
            phase    <= phase_nxt;
            started  <= 1'b1;
            elapsed  <= elapsed + CNT_W'(1);
        end
    end

    // A periodic phase always stays below N (R4, R5).
    assert_phase_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && pic_is_periodic(mode_q)) |-> (phase < init_cnt));

endmodule

// File: rtl/pic_wave_decode.sv
// Module: turns the channel state into the output level and readable count
// for the captured mode. Purely combinational. Assumes N >= 1, and a
// periodic phase below N.
module pic_wave_decode #(
    parameter int CNT_W = 16
) (
    input  logic                 armed,
    input  pic_pkg::pic_mode_e   mode_q,
    input  logic [CNT_W:0]       init_cnt,
    input  logic [CNT_W:0]       phase,
    input  logic                 started,
    input  logic [CNT_W-1:0]     elapsed,
    output logic                 wave,
    output logic [CNT_W-1:0]     count_val
);
    import pic_pkg::*;

    localparam int EXT_W = CNT_W + 1;

    logic [EXT_W:0]   init_x;
    logic [EXT_W:0]   twice;
    logic [EXT_W:0]   sq_left;
    logic [EXT_W-1:0] half;

    assign init_x = {1'b0, init_cnt};
    assign twice  = {phase, 1'b0};
    assign half   = EXT_W'((init_x + (EXT_W+1)'(1)) >> 1);

    // Square-wave readback: N minus twice the phase, folded into one period.
    always_comb begin
        if (twice < init_x) sq_left = init_x - twice;
        else                sq_left = {init_cnt, 1'b0} - twice;
    end

    // Output level and readback selected by mode.
    always_comb begin
        wave      = 1'b0;
        count_val = '0;
        if (armed) begin
            unique case (mode_q)
                PM_TERM: begin
                    wave      = (phase >= init_cnt);
                    count_val = CNT_W'(init_cnt) - elapsed;
                end
                PM_ONESHOT: begin
                    wave      = (phase < init_cnt);
                    count_val = CNT_W'(init_cnt) - elapsed;
                end
                PM_RATE: begin
                    wave      = started && (phase == '0);
                    count_val = CNT_W'(init_cnt - phase);
                end
                PM_SQUARE: begin
                    wave      = (phase < half);
                    count_val = CNT_W'(sq_left);
                end
                PM_SW_STB, PM_HW_STB: begin
                    wave      = (phase == init_cnt);
                    count_val = CNT_W'(init_cnt) - elapsed;
                end
                default: begin
                    wave      = 1'b0;
                    count_val = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/pic_channel.sv
// Module: top of one interval counter channel. Detects gate edges, holds
// the counting state and decodes the waveform and readback. Assumes
// load/mode come from a control block, and tick is a one-cycle enable.
module pic_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [2:0]       mode,
    input  logic             gate,
    output logic             out,
    output logic [CNT_W-1:0] count
);
    import pic_pkg::*;

    logic             gate_rise;
    logic             armed;
    pic_mode_e        mode_q;
    logic [CNT_W:0]   init_cnt;
    logic [CNT_W:0]   phase;
    logic             started;
    logic [CNT_W-1:0] elapsed;
    logic             count_en;
    logic             restart;

    pic_gate_edge u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .gate      (gate),
        .gate_rise (gate_rise)
    );

    pic_tick_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .load      (load),
        .load_val  (load_val),
        .mode_in   (mode),
        .gate      (gate),
        .gate_rise (gate_rise),
        .armed     (armed),
        .mode_q    (mode_q),
        .init_cnt  (init_cnt),
        .phase     (phase),
        .started   (started),
        .elapsed   (elapsed),
        .count_en  (count_en),
        .restart   (restart)
    );

    pic_wave_decode #(.CNT_W(CNT_W)) u_dec (
        .armed     (armed),
        .mode_q    (mode_q),
        .init_cnt  (init_cnt),
        .phase     (phase),
        .started   (started),
        .elapsed   (elapsed),
        .wave      (out),
        .count_val (count)
    );

    // Readback equals the loaded value one cycle after a load.
    assert_load_readback_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val)));

    // Quiet before the first load.
    assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (!out && count == '0));

    // Mode 0 output stays high once it has risen.
    assert_term_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && mode_q == PM_TERM && out && !load) |=> out);

    // Strobe pulse lasts a single counted tick.
    assert_strobe_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && (mode_q == PM_SW_STB || mode_q == PM_HW_STB) && out &&
         count_en && !load && !restart) |=> !out);

    // Rate pulse drops after one counted tick when N > 1.
    assert_rate_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && mode_q == PM_RATE && out && count_en && !load && !restart &&
         init_cnt != (CNT_W+1)'(1)) |=> !out);

    // Gate low freezes the count in modes 0 and 4.
    assert_gate_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && (mode_q == PM_TERM || mode_q == PM_SW_STB) && !gate && !load)
        |=> $stable(count));

endmodule

// File: tb/tb_pic_channel.sv
module tb_pic_channel;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tick;
    logic        load;
    logic [15:0] load_val;
    logic [2:0]  mode;
    logic        gate;
    logic        out;
    logic [15:0] count;

    always #4 clk = ~clk;

    pic_channel dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(load),
        .load_val(load_val), .mode(mode), .gate(gate),
        .out(out), .count(count)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model state, in elapsed-tick terms.
    int m_n, m_d, m_mode;
    bit m_armed, m_gprev;

    function automatic int norm(input int c);
        if (c == 6) return 2;
        if (c == 7) return 3;
        return c;
    endfunction

    function automatic int exp_out();
        if (!m_armed) return 0;
        case (m_mode)
            0: return (m_d >= m_n) ? 1 : 0;
            1: return (m_d < m_n) ? 1 : 0;
            2: return ((m_d % m_n) == 0 && m_d != 0) ? 1 : 0;
            3: return ((m_d % m_n) < ((m_n + 1) / 2)) ? 1 : 0;
            default: return (m_d == m_n) ? 1 : 0;
        endcase
    endfunction

    function automatic int exp_cnt();
        if (!m_armed) return 0;
        case (m_mode)
            2: return (m_n - (m_d % m_n)) & 16'hFFFF;
            3: return (m_n - ((2 * m_d) % m_n)) & 16'hFFFF;
            default: return (m_n - m_d) & 16'hFFFF;
        endcase
    endfunction

    function automatic string mode_tag(input int raw);
        if (raw >= 6) return "R11";
        case (raw)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, update the model at posedge, compare after.
    task automatic step(input bit ld, input int val, input int md, input bit g,
                        input bit tk, input string otag, input string ctag);
        bit rise;
        @(negedge clk);
        load = ld; load_val = val[15:0]; mode = md[2:0]; gate = g; tick = tk;
        @(posedge clk);
        rise = g && !m_gprev;
        if (ld) begin
            m_n = (val == 0) ? 65536 : val;
            m_mode = norm(md);
            m_d = 0;
            m_armed = 1;
        end else if (m_armed && rise && (m_mode == 1 || m_mode == 2 || m_mode == 3 || m_mode == 5)) begin
            m_d = 0;
        end else if (m_armed && tk && !((m_mode == 0 || m_mode == 4) && !g)) begin
            m_d++;
        end
        m_gprev = g;
        #1;
        chk(otag, int'(out), exp_out());
        chk(ctag, int'(count), exp_cnt());
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        int cur_mode;
        bit g;
        seed = 32'h5EED_0042;
        void'($urandom(seed));
        m_armed = 0; m_gprev = 0; m_n = 1; m_d = 0; m_mode = 0;
        rst_n = 0; tick = 0; load = 0; load_val = 0; mode = 0; gate = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R12: idle output before any load, even with ticks and gate.
        for (int i = 0; i < 4; i++) step(0, 0, 3, i[0], 1, "R12", "R12");

        // R1: zero count stands for 65536.
        step(1, 0, 0, 1, 0, "R1", "R1");
        chk("R1", int'(count), 0);
        step(0, 0, 0, 1, 1, "R1", "R1");
        chk("R1", int'(count), 16'hFFFF);

        // R2: mode 0 with N=5, then held high past terminal.
        step(1, 5, 0, 1, 0, "R2", "R10");
        for (int i = 0; i < 8; i++) step(0, 0, 0, 1, 1, "R2", "R9");

        // R8: gate low suspends mode 0.
        step(1, 6, 0, 1, 1, "R10", "R10");
        step(0, 0, 0, 1, 1, "R8", "R8");
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, "R8", "R8");
        for (int i = 0; i < 6; i++) step(0, 0, 0, 1, 1, "R8", "R8");

        // R7: mode 1 restart on gate rise.
        step(1, 4, 1, 1, 0, "R3", "R10");
        step(0, 0, 1, 1, 1, "R3", "R9");
        step(0, 0, 1, 1, 1, "R3", "R9");
        step(0, 0, 1, 0, 1, "R3", "R9");
        step(0, 0, 1, 1, 1, "R7", "R7");
        chk("R7", int'(count), 4);
        for (int i = 0; i < 5; i++) step(0, 0, 1, 1, 1, "R3", "R9");

        // R11 and R13: alias code 7, then mode input changes without load.
        step(1, 5, 7, 1, 0, "R11", "R11");
        for (int i = 0; i < 12; i++) step(0, 0, i % 8, 1, 1, "R13", "R13");

        // R10: reload mid-count with a simultaneous tick.
        step(1, 3, 2, 1, 1, "R10", "R10");
        chk("R10", int'(count), 3);
        for (int i = 0; i < 7; i++) step(0, 0, 2, 1, 1, "R4", "R9");

        // Random mix of loads, modes, gate and ticks.
        cur_mode = 0; g = 1;
        for (int i = 0; i < 4000; i++) begin
            bit ld;
            int val;
            int md;
            ld = ($urandom % 40) == 0;
            val = (($urandom % 30) == 0) ? 0 : int'($urandom % 12) + 1;
            md = int'($urandom % 8);
            if (ld) cur_mode = md;
            if (($urandom % 9) == 0) g = ~g;
            step(ld, val, md, g, ($urandom % 4) != 0, mode_tag(cur_mode), "R9");
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule